// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a processor whose 16K-word program space is divided into sixteen pages of 1K words each. Every instruction cycle it takes a decoded control-flow command, a 10-bit in-page target, an 8-bit accumulator value and a 4-bit page-select value supplied by the status register. From these it computes the next 14-bit address and drives it out as a register.

The upper four address bits come from the page-select input only on the absolute and accumulator-based transfers. The sequential, table-offset and return paths keep the page that the counter already holds or that the stack stored. The two accumulator-relative forms differ in one way. The plain add clears address bits 8 and 9. The table form keeps them.

An eight-entry return stack holds call return addresses. When a call finds the stack full, it overwrites the oldest entry. When a return finds the stack empty, it yields address zero. Each of these events raises a one-cycle flag.

Top module: `pgpc_seq`

## Requirements
- R1: When `rst` is high at a clock edge, the reset takes priority over any command. After that edge `pc` is 0x0000, both flags are low and the return stack is empty.
- R2: Command code 0, and the spare code 7, advance `pc` by one. The value wraps from 0x3FFF to 0x0000.
- R3: Command code 1 (jump) loads `pc` with {page, imm}.
- R4: Command code 2 (call) loads `pc` with {page, imm}. It also pushes the old `pc`+1, taken modulo 2^14, onto the return stack.
- R5: Command code 3 (return) loads `pc` from the newest stack entry and removes that entry.
- R6: Command code 4 (load from accumulator) loads `pc` with page in bits 13..10, zero in bits 9..8 and acc in bits 7..0.
- R7: Command code 5 (add accumulator) sets bits 7..0 to (pc[7..0]+acc) mod 256, bits 9..8 to zero and bits 13..10 to page.
- R8: Command code 6 (table add) sets bits 7..0 to (pc[7..0]+acc) mod 256 and leaves bits 13..8 of `pc` unchanged.
- R9: A call made while eight entries are held replaces the oldest entry, so the eight newest return addresses remain. In that case `ovf` is high for exactly the following cycle; otherwise `ovf` is low.
- R10: A return made while the stack is empty loads `pc` with 0x0000 and sets `udf` high for exactly the following cycle; otherwise `udf` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Control-flow command code |
| imm | input | 10 | In-page target for jump and call |
| acc | input | 8 | Accumulator value |
| page | input | 4 | Page-select bits from status register |
| pc | output | 14 | Fetch address |
| ovf | output | 1 | Return stack overflowed on the previous cycle |
| udf | output | 1 | Return stack underflowed on the previous cycle |

## Verification
Two pairs of events can land in the same cycle. The first pair is a call's counter load and its stack overflow. The bench makes nine calls in a row, with distinct targets, and checks on the ninth that the jump target and the overflow pulse appear together. It then unwinds with returns and checks that exactly the eight newest return addresses come back, in order. The second pair is reset and a call: the bench holds reset while a call is presented. It then checks that the counter is zero and that a following return underflows, which proves that neither the jump nor the push survived.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LDA  = 3'd4,
    OP_ADDA = 3'd5,
    OP_TBL  = 3'd6,
    OP_SPR  = 3'd7
  } flow_op_e;
endpackage

// File: rtl/pgpc_addr.sv
module pgpc_addr
  import pgpc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8
) (
  input  flow_op_e                  op,
  input  logic [PAGE_W+OFS_W-1:0]   pc_cur,
  input  logic [OFS_W-1:0]          imm,
  input  logic [ACC_W-1:0]          acc,
  input  logic [PAGE_W-1:0]         page,
  input  logic [PAGE_W+OFS_W-1:0]   stack_top,
  output logic [PAGE_W+OFS_W-1:0]   pc_nxt,
  output logic                      push,
  output logic                      pop
);
  localparam int AW    = PAGE_W + OFS_W;
  localparam int GAP_W = OFS_W - ACC_W;

  function automatic logic [AW-1:0] f_paged(input logic [PAGE_W-1:0] pg,
                                            input logic [OFS_W-1:0] ofs);
    return {pg, ofs};
  endfunction

  function automatic logic [AW-1:0] f_acc_abs(input logic [PAGE_W-1:0] pg,
                                              input logic [ACC_W-1:0] a);
    return {pg, {GAP_W{1'b0}}, a};
  endfunction

  function automatic logic [ACC_W-1:0] f_low_sum(input logic [AW-1:0] cur,
                                                 input logic [ACC_W-1:0] a);
    logic [ACC_W-1:0] s;
    s = cur[ACC_W-1:0] + a;
    return s;
  endfunction

  function automatic logic [AW-1:0] f_rel_clear(input logic [PAGE_W-1:0] pg,
                                                input logic [AW-1:0] cur,
                                                input logic [ACC_W-1:0] a);
    return {pg, {GAP_W{1'b0}}, f_low_sum(cur, a)};
  endfunction

  function automatic logic [AW-1:0] f_rel_keep(input logic [AW-1:0] cur,
                                               input logic [ACC_W-1:0] a);
    return {cur[AW-1:ACC_W], f_low_sum(cur, a)};
  endfunction

  always_comb begin
    push = (op == OP_CALL);
    pop  = (op == OP_RET);
    unique case (op)
      OP_JMP, OP_CALL: pc_nxt = f_paged(page, imm);
      OP_RET:          pc_nxt = stack_top;
      OP_LDA:          pc_nxt = f_acc_abs(page, acc);
      OP_ADDA:         pc_nxt = f_rel_clear(page, pc_cur, acc);
      OP_TBL:          pc_nxt = f_rel_keep(pc_cur, acc);
      default:         pc_nxt = pc_cur + 1'b1;
    endcase
  end
endmodule

// File: rtl/pgpc_stack.sv
module pgpc_stack #(
  parameter int AW    = 14,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          full,
  output logic          empty,
  output logic          ovf_evt,
  output logic          udf_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] top_idx, up_idx, dn_idx;
  logic [CNT_W-1:0] cnt;

  assign up_idx  = (top_idx == PTR_W'(DEPTH - 1)) ? '0 : top_idx + 1'b1;
  assign dn_idx  = (top_idx == '0) ? PTR_W'(DEPTH - 1) : top_idx - 1'b1;
  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign ovf_evt = push && full;
  assign udf_evt = pop && empty;
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      top_idx <= '0;
      cnt     <= '0;
    end else if (push) begin
      top_idx <= up_idx;
      if (!full) cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      top_idx <= dn_idx;
      cnt     <= cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst && push && (up_idx == PTR_W'(g))) mem[g] <= din;
    end
  end
endmodule

// File: rtl/pgpc_seq.sv
module pgpc_seq
  import pgpc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              op,
  input  logic [OFS_W-1:0]        imm,
  input  logic [ACC_W-1:0]        acc,
  input  logic [PAGE_W-1:0]       page,
  output logic [PAGE_W+OFS_W-1:0] pc,
  output logic                    ovf,
  output logic                    udf
);
  localparam int AW = PAGE_W + OFS_W;

  logic [AW-1:0] pc_q, pc_nxt, st_top, ret_addr;
  logic          st_push, st_pop, st_full, st_empty, ovf_evt, udf_evt;
  logic          ovf_q, udf_q;

  assign ret_addr = pc_q + 1'b1;

  pgpc_addr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)) u_addr (
    .op       (flow_op_e'(op)),
    .pc_cur   (pc_q),
    .imm      (imm),
    .acc      (acc),
    .page     (page),
    .stack_top(st_top),
    .pc_nxt   (pc_nxt),
    .push     (st_push),
    .pop      (st_pop)
  );

  pgpc_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .push   (st_push),
    .pop    (st_pop),
    .din    (ret_addr),
    .top    (st_top),
    .full   (st_full),
    .empty  (st_empty),
    .ovf_evt(ovf_evt),
    .udf_evt(udf_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      pc_q  <= pc_nxt;
      ovf_q <= ovf_evt;
      udf_q <= udf_evt;
    end
  end

  assign pc  = pc_q;
  assign ovf = ovf_q;
  assign udf = udf_q;
endmodule

// File: rtl/pgpc_seq_chk.sv
module pgpc_seq_chk
  import pgpc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int ACC_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              op,
  input logic [OFS_W-1:0]        imm,
  input logic [ACC_W-1:0]        acc,
  input logic [PAGE_W-1:0]       page,
  input logic [PAGE_W+OFS_W-1:0] pc,
  input logic                    ovf,
  input logic                    udf,
  input logic                    push,
  input logic                    pop,
  input logic                    full,
  input logic                    empty
);
  localparam int AW = PAGE_W + OFS_W;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc == '0 && !ovf && !udf)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SEQ || op == OP_SPR) |=> pc == AW'($past(pc) + 1'b1)); // R2
  AST_JMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JMP) |=> pc == {$past(page), $past(imm)}); // R3
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CALL) |-> push && !pop); // R4
  AST_LDA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LDA) |=> (pc[AW-1:OFS_W] == $past(page) && pc[OFS_W-1:ACC_W] == '0
                        && pc[ACC_W-1:0] == $past(acc))); // R6
  AST_ADDA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADDA) |=> (pc[AW-1:OFS_W] == $past(page) && pc[OFS_W-1:ACC_W] == '0)); // R7
  AST_TBL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TBL) |=> pc[AW-1:ACC_W] == $past(pc[AW-1:ACC_W])); // R8
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf); // R9
  AST_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    !(push && full) |=> !ovf); // R9
  AST_UDF_PULSE: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (udf && pc == '0)); // R10
  AST_NO_UDF: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty) |=> !udf); // R10
endmodule

bind pgpc_seq pgpc_seq_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .imm(imm), .acc(acc), .page(page),
  .pc(pc), .ovf(ovf), .udf(udf),
  .push(st_push), .pop(st_pop), .full(st_full), .empty(st_empty)
);

// File: tb/pgpc_seq_tb.sv
`timescale 1ns/1ps
module pgpc_seq_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op;
  logic [9:0] imm;
  logic [7:0] acc;
  logic [3:0] page;
  logic [13:0] pc;
  logic       ovf, udf;

  int checks = 0;
  int fails  = 0;

  int mpc;
  int stk[$];
  bit movf, mudf;

  always #10 clk = ~clk;

  pgpc_seq u_dut (.clk(clk), .rst(rst), .op(op), .imm(imm), .acc(acc),
                  .page(page), .pc(pc), .ovf(ovf), .udf(udf));

  task automatic compare(input string tag);
    checks++;
    if (pc !== 14'(mpc) || ovf !== movf || udf !== mudf) begin
      fails++;
      $display("FAIL %s: actual pc=%h ovf=%b udf=%b expected pc=%h ovf=%b udf=%b",
               tag, pc, ovf, udf, 14'(mpc), movf, mudf);
    end
  endtask

  task automatic step(input int o, input int i, input int a, input int p, input string tag);
    int npc;
    op = 3'(o); imm = 10'(i); acc = 8'(a); page = 4'(p);
    movf = 0; mudf = 0;
    case (o)
      1: npc = p * 1024 + i;
      2: begin
        if (stk.size() == 8) begin void'(stk.pop_front()); movf = 1; end
        stk.push_back((mpc + 1) % 16384);
        npc = p * 1024 + i;
      end
      3: begin
        if (stk.size() == 0) begin npc = 0; mudf = 1; end
        else npc = stk.pop_back();
      end
      4: npc = p * 1024 + a;
      5: npc = p * 1024 + ((mpc % 256 + a) % 256);
      6: npc = (mpc / 256) * 256 + ((mpc % 256 + a) % 256);
      default: npc = (mpc + 1) % 16384;
    endcase
    mpc = npc;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    op = 3'd2; imm = 10'h155; acc = 8'h0; page = 4'h3;
    @(posedge clk);
    @(negedge clk);
    stk.delete(); mpc = 0; movf = 0; mudf = 0;
    compare(tag);
    rst = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op = 3'd0; imm = '0; acc = '0; page = '0;
    mpc = 0;
    @(negedge clk);
    do_reset("R1 reset with call pending");
    step(0, 0, 0, 0, "R2 seq");
    step(0, 0, 0, 0, "R2 seq");
    step(7, 0, 0, 9, "R2 spare code");
    step(1, 'h155, 0, 3, "R3 jump");
    step(4, 0, 'hA7, 5, "R6 load acc");
    step(1, 'h2F0, 0, 2, "R3 jump");
    step(5, 0, 'h20, 9, "R7 add acc wraps low byte");
    step(1, 'h3F0, 0, 1, "R3 jump");
    step(6, 0, 'h25, 'hE, "R8 table keeps bits 13..8");
    step(1, 'h3FF, 0, 'hF, "R3 jump top");
    step(0, 0, 0, 0, "R2 wrap to zero");
    step(1, 'h3FF, 0, 'hF, "R3 jump top");
    step(2, 'h010, 0, 4, "R4 call return wraps");
    step(3, 0, 0, 0, "R5 return");
    for (int k = 0; k < 9; k++)
      step(2, 'h040 + k * 8, 0, k, (k == 8) ? "R9 call overflows" : "R4 call");
    step(0, 0, 0, 0, "R9 flag drops");
    for (int k = 0; k < 8; k++) step(3, 0, 0, 0, "R5 R9 return newest eight");
    step(3, 0, 0, 0, "R10 return empty");
    step(0, 0, 0, 0, "R10 flag drops");
    step(2, 'h100, 0, 6, "R4 call");
    step(2, 'h200, 0, 7, "R4 call");
    do_reset("R1 reset beats call");
    step(3, 0, 0, 0, "R1 R10 stack emptied by reset");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule